// File: doc/BRIEF.md
# Page-Mode DRAM Burst Read Controller

This block fills one 32-byte cache line from an asynchronous page-mode DRAM. A single start pulse with a line address opens one row under a single active-low row strobe. The controller then walks four column addresses on the shared address bus with an active-low column strobe and returns four 64-bit beats, each marked by a one-cycle valid strobe. A done pulse marks the last beat. After the burst the row strobe stays high for a parameterised precharge interval before the next request can open a row.

An elaboration parameter selects the beat cadence. In fast-page mode the four beats take 5, 3, 3 and 3 cycles. In extended-data-out mode they take 5, 2, 2 and 2 cycles, because the part keeps the previous word driven while the next column is being latched. The first-beat length, both follow-on lengths and the precharge length are all parameters, so every strobe edge lands on a known cycle.

The line address is the 14-bit row followed by the 14-bit column. The two lowest column bits pick the word that is fetched first, and the column wraps inside the aligned group of four.

Top module: `dram_page_burst_ctrl`

## Requirements
- R1: While reset is held and afterwards until a request is accepted, dram_ras_n, dram_cas_n and dram_oe_n are 1, req_ready is 1, and rsp_valid and rsp_done are 0. A reset taken in the middle of a burst returns the block to this state on the next cycle.
- R2: In the first cycle after a start is accepted, dram_ras_n is 0, dram_cas_n is 1 and dram_addr carries the row (req_line bits 27..14). dram_cas_n is never 0 while dram_ras_n is 1.
- R3: dram_ras_n stays 0 for one unbroken run over the whole burst: 14 cycles in fast-page mode and 11 in extended-data-out mode, with the default lengths.
- R4: Beat k (k = 0..3) uses column {c[13:2], (c[1:0] + k) mod 4}, where c is req_line bits 13..0. dram_addr carries that column in every cycle of beat k except the row cycle.
- R5: In fast-page mode the beat windows are 5, 3, 3 and 3 cycles long. dram_cas_n is 1 in the first cycle of each window and 0 in the rest.
- R6: In extended-data-out mode the beat windows are 5, 2, 2 and 2 cycles long, with the same column-strobe shape as R5.
- R7: dram_oe_n is 0 from the second burst cycle through the last burst cycle and 1 at all other times.
- R8: dram_dq_in is sampled in the last cycle of each beat window. It appears on rsp_data with rsp_valid high for exactly the next cycle, and rsp_word carries that beat's two low column bits.
- R9: rsp_done is 1 together with the fourth rsp_valid of a burst and 0 at all other times.
- R10: Between two bursts dram_ras_n is 1 for at least PRECHARGE cycles (default 3). req_ready rises in the last precharge cycle, so a start held at that point reopens the row after exactly PRECHARGE high cycles.
- R11: A req_start seen while req_ready is 0 has no effect. No new row strobe follows it and req_line is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start request, taken when req_ready is 1 |
| req_line | input | 28 | Line address: row in bits 27..14, column in bits 13..0 |
| req_ready | output | 1 | Controller can accept a start this cycle |
| rsp_valid | output | 1 | One-cycle strobe marking a returned beat |
| rsp_data | output | 64 | Returned beat data |
| rsp_word | output | 2 | Low column bits of the returned beat |
| rsp_done | output | 1 | Pulses with the last beat of a line |
| dram_addr | output | 14 | Multiplexed row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_in | input | 64 | Read data from the DRAM |

## Verification
The hardest case to reach from the ports is a start arriving in exactly the last precharge cycle. Only that timing shows that the row strobe stays high for the full precharge and no more. The bench counts cycles from a first request, then raises the second start at the very cycle req_ready should rise, and checks where the row strobe falls. Two other cases need deliberate stimulus: a start pulse in the middle of a burst, which must be ignored, and a column at the top of the address range, which must wrap inside its aligned group of four rather than carry into the upper column bits. Both bursts run the same stimulus on a fast-page and an extended-data-out instance side by side, with a behavioural DRAM that latches addresses on the strobe edges.

// File: rtl/dram_burst_pkg.sv
// Shared types and helpers for the page-mode DRAM burst read controller.
package dram_burst_pkg;

    // Phase of the controller: waiting, row open, or row precharging.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_BURST = 2'd1,
        SEQ_PRECH = 2'd2
    } seq_state_e;

    // Number of cycles the row strobe is held low for one burst.
    function automatic int burst_total(input int lead, input int next, input int beats);
        return lead + (beats - 1) * next;
    endfunction

endpackage

// File: rtl/dram_burst_seq.sv
// Burst sequencer: counts the cycles of each beat window and the precharge
// interval, and tells the strobe decode which phase the burst is in.
// Assumes LEAD_CYC >= 2, NEXT_CYC >= 2, PRECHARGE >= 1 and BEATS a power
// of two that is at least 2.
module dram_burst_seq
    import dram_burst_pkg::*;
#(
    parameter int BEATS     = 4,
    parameter int LEAD_CYC  = 5,
    parameter int NEXT_CYC  = 3,
    parameter int PRECHARGE = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_start,
    output logic                     req_ready,
    output logic                     accept,
    output logic                     burst_open,
    output logic                     row_phase,
    output logic                     col_strobe,
    output logic                     beat_end,
    output logic                     final_beat,
    output logic [$clog2(BEATS)-1:0] beat_idx
);

    localparam int WORD_W  = $clog2(BEATS);
    localparam int LONGEST = (LEAD_CYC > NEXT_CYC) ? LEAD_CYC : NEXT_CYC;
    localparam int SUB_W   = $clog2(LONGEST + 1);
    localparam int PRE_W   = $clog2(PRECHARGE + 1);

    seq_state_e        state_q;
    logic [WORD_W-1:0] beat_q;
    logic [SUB_W-1:0]  sub_q;
    logic [PRE_W-1:0]  pre_q;
    logic [SUB_W-1:0]  len_m1;
    logic              pre_last;

    // Length of the current beat window minus one.
    always_comb begin
        len_m1 = (beat_q == '0) ? SUB_W'(LEAD_CYC - 1) : SUB_W'(NEXT_CYC - 1);
    end

    // Phase flags derived from the counters.
    always_comb begin
        burst_open = (state_q == SEQ_BURST);
        row_phase  = burst_open && (beat_q == '0) && (sub_q == '0);
        col_strobe = burst_open && (sub_q != '0);
        beat_end   = burst_open && (sub_q == len_m1);
        final_beat = (beat_q == WORD_W'(BEATS - 1));
        pre_last   = (state_q == SEQ_PRECH) && (pre_q == PRE_W'(PRECHARGE - 1));
        req_ready  = (state_q == SEQ_IDLE) || pre_last;
        accept     = req_start && req_ready;
        beat_idx   = beat_q;
    end

    // Advance through the beat windows, then the precharge interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            beat_q  <= '0;
            sub_q   <= '0;
            pre_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        state_q <= SEQ_BURST;
                        beat_q  <= '0;
                        sub_q   <= '0;
                    end
                end
                SEQ_BURST: begin
                    if (beat_end) begin
                        sub_q <= '0;
                        if (final_beat) begin
                            state_q <= SEQ_PRECH;
                            pre_q   <= '0;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end else begin
                        sub_q <= sub_q + 1'b1;
                    end
                end
                SEQ_PRECH: begin
                    if (pre_last) begin
                        if (accept) begin
                            state_q <= SEQ_BURST;
                            beat_q  <= '0;
                            sub_q   <= '0;
                        end else begin
                            state_q <= SEQ_IDLE;
                        end
                    end else begin
                        pre_q <= pre_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dram_col_walk.sv
// Address holder: latches the row and starting column of an accepted
// request and produces the column for the current beat, wrapping inside
// the aligned group of BEATS words. Assumes BEATS is a power of two >= 2.
module dram_col_walk #(
    parameter int ADDR_W = 14,
    parameter int BEATS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [2*ADDR_W-1:0]      line_in,
    input  logic [$clog2(BEATS)-1:0] beat_idx,
    output logic [ADDR_W-1:0]        row_out,
    output logic [ADDR_W-1:0]        col_out
);

    localparam int WORD_W = $clog2(BEATS);

    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;
    logic [WORD_W-1:0] word_sum;

    // Capture the line address when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load) begin
            row_q <= line_in[2*ADDR_W-1:ADDR_W];
            col_q <= line_in[ADDR_W-1:0];
        end
    end

    // Offset only the low bits, so the column wraps within the line.
    always_comb begin
        word_sum = col_q[WORD_W-1:0] + beat_idx;
        row_out  = row_q;
        col_out  = {col_q[ADDR_W-1:WORD_W], word_sum};
    end

endmodule

// File: rtl/dram_beat_capture.sv
// Beat capture: registers read data at the end of each beat window and
// presents it for one cycle with its word index and an end-of-line flag.
module dram_beat_capture #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              take_last,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [WORD_W-1:0] word_in,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic [WORD_W-1:0] word,
    output logic              done
);

    // One-cycle valid and done strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            done  <= 1'b0;
        end else begin
            valid <= take;
            done  <= take && take_last;
        end
    end

    // Hold the last captured beat and its word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            word <= '0;
        end else if (take) begin
            data <= dq_in;
            word <= word_in;
        end
    end

endmodule

// File: rtl/dram_page_burst_ctrl.sv
// Page-mode DRAM burst read controller (top). It accepts one line request,
// opens the row once, walks BEATS columns at the cadence chosen by
// EDO_MODE (0: fast page, 1: extended data out), returns each beat, then
// precharges the row. Strobes are decoded from the sequencer state flops,
// so address and strobes change on the same clock edge. Assumes the DRAM
// meets its setup times within one clock period.
module dram_page_burst_ctrl #(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 64,
    parameter int BEATS     = 4,
    parameter int EDO_MODE  = 0,
    parameter int LEAD_CYC  = 5,
    parameter int FPM_CYC   = 3,
    parameter int EDO_CYC   = 2,
    parameter int PRECHARGE = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_start,
    input  logic [2*ADDR_W-1:0]      req_line,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_data,
    output logic [$clog2(BEATS)-1:0] rsp_word,
    output logic                     rsp_done,
    output logic [ADDR_W-1:0]        dram_addr,
    output logic                     dram_ras_n,
    output logic                     dram_cas_n,
    output logic                     dram_oe_n,
    input  logic [DATA_W-1:0]        dram_dq_in
);

    localparam int WORD_W   = $clog2(BEATS);
    localparam int NEXT_CYC = (EDO_MODE != 0) ? EDO_CYC : FPM_CYC;

    logic              accept;
    logic              burst_open;
    logic              row_phase;
    logic              col_strobe;
    logic              beat_end;
    logic              final_beat;
    logic [WORD_W-1:0] beat_idx;
    logic [ADDR_W-1:0] row_addr;
    logic [ADDR_W-1:0] col_addr;

    dram_burst_seq #(
        .BEATS    (BEATS),
        .LEAD_CYC (LEAD_CYC),
        .NEXT_CYC (NEXT_CYC),
        .PRECHARGE(PRECHARGE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_start (req_start),
        .req_ready (req_ready),
        .accept    (accept),
        .burst_open(burst_open),
        .row_phase (row_phase),
        .col_strobe(col_strobe),
        .beat_end  (beat_end),
        .final_beat(final_beat),
        .beat_idx  (beat_idx)
    );

    dram_col_walk #(
        .ADDR_W(ADDR_W),
        .BEATS (BEATS)
    ) u_cols (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .line_in (req_line),
        .beat_idx(beat_idx),
        .row_out (row_addr),
        .col_out (col_addr)
    );

    dram_beat_capture #(
        .DATA_W(DATA_W),
        .WORD_W(WORD_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (beat_end),
        .take_last(final_beat),
        .dq_in    (dram_dq_in),
        .word_in  (col_addr[WORD_W-1:0]),
        .valid    (rsp_valid),
        .data     (rsp_data),
        .word     (rsp_word),
        .done     (rsp_done)
    );

    // Strobe and address decode from the sequencer phase.
    always_comb begin
        dram_ras_n = !burst_open;
        dram_cas_n = !col_strobe;
        dram_oe_n  = !(burst_open && !row_phase);
        dram_addr  = row_phase ? row_addr : col_addr;
    end

endmodule

// File: rtl/dram_page_burst_chk.sv
// Protocol checker for the burst controller, attached by bind. It watches
// the strobes at the ports and tracks run lengths with its own counters.
module dram_page_burst_chk #(
    parameter int BEATS     = 4,
    parameter int EDO_MODE  = 0,
    parameter int LEAD_CYC  = 5,
    parameter int FPM_CYC   = 3,
    parameter int EDO_CYC   = 2,
    parameter int PRECHARGE = 3
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_valid,
    input logic rsp_done,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_oe_n
);

    localparam int NEXT_CYC = (EDO_MODE != 0) ? EDO_CYC : FPM_CYC;
    localparam int TOTAL    = dram_burst_pkg::burst_total(LEAD_CYC, NEXT_CYC, BEATS);
    localparam int HW       = $clog2(PRECHARGE + 1);
    localparam int LW       = $clog2(TOTAL + 2);
    localparam int FW       = $clog2(BEATS + 2);

    logic [HW-1:0] hi_cnt;
    logic [LW-1:0] lo_cnt;
    logic [FW-1:0] fall_cnt;
    logic          cas_q;

    // Run-length counters for the row strobe and column strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt   <= HW'(PRECHARGE);
            lo_cnt   <= '0;
            fall_cnt <= '0;
            cas_q    <= 1'b1;
        end else begin
            cas_q <= dram_cas_n;
            if (!dram_ras_n)                 hi_cnt <= '0;
            else if (hi_cnt < HW'(PRECHARGE)) hi_cnt <= hi_cnt + 1'b1;
            if (dram_ras_n)                   lo_cnt <= '0;
            else if (lo_cnt < LW'(TOTAL + 1)) lo_cnt <= lo_cnt + 1'b1;
            if (dram_ras_n)                   fall_cnt <= '0;
            else if (cas_q && !dram_cas_n && fall_cnt < FW'(BEATS + 1))
                fall_cnt <= fall_cnt + 1'b1;
        end
    end

    // R2: the column strobe only falls under an open row.
    p_cas_needs_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R2: the row is latched with the column strobe still high.
    p_row_before_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> dram_cas_n);

    // R3: one unbroken row strobe per burst of the expected length.
    p_ras_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (lo_cnt == LW'(TOTAL)));

    // R5: exactly BEATS column latches under each row strobe.
    p_four_col_latches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (fall_cnt == FW'(BEATS)));

    // R7: output enable only while a row is open.
    p_oe_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> !dram_ras_n);

    // R9: the end-of-line flag accompanies a beat.
    p_done_on_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> rsp_valid);

    // R10: the row stays precharged long enough before reopening.
    p_precharge_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_cnt >= HW'(PRECHARGE)));

    // R11: no acceptance while a row is open.
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> !req_ready);

endmodule

bind dram_page_burst_ctrl dram_page_burst_chk #(
    .BEATS    (BEATS),
    .EDO_MODE (EDO_MODE),
    .LEAD_CYC (LEAD_CYC),
    .FPM_CYC  (FPM_CYC),
    .EDO_CYC  (EDO_CYC),
    .PRECHARGE(PRECHARGE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_done  (rsp_done),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_oe_n (dram_oe_n)
);

// File: tb/dram_page_burst_ctrl_bench.sv
`timescale 1ns/1ps

// Behavioural DRAM: latches row and column on strobe falls seen mid-cycle
// and drives a word derived from both. EDO holds data while CAS is high.
module dram_behav_model #(
    parameter int EDO = 0
) (
    input  logic        clk,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        oe_n,
    input  logic [13:0] addr,
    output logic [63:0] dq
);
    logic [13:0] row_l = '0;
    logic [13:0] col_l = '0;
    logic        ras_q = 1'b1;
    logic        cas_q = 1'b1;

    initial dq = '0;

    always @(negedge clk) begin
        if (!ras_n && ras_q) row_l = addr;
        if (!cas_n && cas_q) col_l = addr;
        ras_q = ras_n;
        cas_q = cas_n;
        if (!oe_n && !ras_n && (!cas_n || EDO != 0))
            dq = {4'hD, row_l, 2'b00, col_l, 16'hBEEF, ~col_l};
        else
            dq = '0;
    end
endmodule

module dram_page_burst_ctrl_bench;

    localparam int F  = 5;
    localparam int NF = 3;
    localparam int NE = 2;
    localparam int P  = 3;
    localparam int TF = F + 3 * NF;

    // {line address, column expected on the last beat}
    localparam logic [41:0] VEC [6] = '{
        {14'h0000, 14'h0000, 14'h0003},
        {14'h1234, 14'h0ABD, 14'h0ABC},
        {14'h3FFF, 14'h3FFF, 14'h3FFE},
        {14'h2AAA, 14'h1556, 14'h1555},
        {14'h0001, 14'h2003, 14'h2002},
        {14'h1F0F, 14'h0F08, 14'h0F0B}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_f = 1'b0;
    logic        start_e = 1'b0;
    logic [27:0] line = '0;

    logic        rdy_f, val_f, done_f, ras_f, cas_f, oe_f;
    logic [63:0] data_f, dq_f;
    logic [1:0]  word_f;
    logic [13:0] addr_f;
    logic        rdy_e, val_e, done_e, ras_e, cas_e, oe_e;
    logic [63:0] data_e, dq_e;
    logic [1:0]  word_e;
    logic [13:0] addr_e;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    dram_page_burst_ctrl #(.EDO_MODE(0), .PRECHARGE(P)) u_dram_page_burst_ctrl (
        .clk(clk), .rst_n(rst_n), .req_start(start_f), .req_line(line),
        .req_ready(rdy_f), .rsp_valid(val_f), .rsp_data(data_f), .rsp_word(word_f),
        .rsp_done(done_f), .dram_addr(addr_f), .dram_ras_n(ras_f),
        .dram_cas_n(cas_f), .dram_oe_n(oe_f), .dram_dq_in(dq_f));

    dram_page_burst_ctrl #(.EDO_MODE(1), .PRECHARGE(P)) u_dram_page_burst_ctrl_edo (
        .clk(clk), .rst_n(rst_n), .req_start(start_e), .req_line(line),
        .req_ready(rdy_e), .rsp_valid(val_e), .rsp_data(data_e), .rsp_word(word_e),
        .rsp_done(done_e), .dram_addr(addr_e), .dram_ras_n(ras_e),
        .dram_cas_n(cas_e), .dram_oe_n(oe_e), .dram_dq_in(dq_e));

    dram_behav_model #(.EDO(0)) u_mem_f (.clk(clk), .ras_n(ras_f), .cas_n(cas_f),
        .oe_n(oe_f), .addr(addr_f), .dq(dq_f));
    dram_behav_model #(.EDO(1)) u_mem_e (.clk(clk), .ras_n(ras_e), .cas_n(cas_e),
        .oe_n(oe_e), .addr(addr_e), .dq(dq_e));

    function automatic logic [63:0] pat(input logic [13:0] r, input logic [13:0] c);
        return {4'hD, r, 2'b00, c, 16'hBEEF, ~c};
    endfunction

    function automatic logic [13:0] col_of(input logic [13:0] c, input int k);
        logic [1:0] lo;
        lo = c[1:0] + 2'(k);
        return {c[13:2], lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare one instance's ports against the schedule for cycle c.
    task automatic check_cycle(input int c, input bit edo, input logic [27:0] ln,
                               input logic ras, input logic cas, input logic oe,
                               input logic [13:0] addr, input logic val,
                               input logic [63:0] data, input logic [1:0] word,
                               input logic dn, input logic rdy);
        int n, t, k;
        bit in_b, first, exp_val;
        logic [13:0] r, c0, ck;
        string ctag;
        n = edo ? NE : NF;
        t = F + 3 * n;
        r = ln[27:14];
        c0 = ln[13:0];
        in_b = (c < t);
        first = (c == 0) || (in_b && c >= F && ((c - F) % n) == 0);
        k = (c < F) ? 0 : 1 + (c - F) / n;
        if (k > 3) k = 3;
        ctag = edo ? "R6 cas_n" : "R5 cas_n";
        chk(ras == !in_b, "R3 R11 ras_n", 64'(ras), 64'(!in_b));
        chk(cas == (in_b ? first : 1'b1), ctag, 64'(cas), 64'(in_b ? first : 1'b1));
        chk(oe == (in_b ? (c == 0) : 1'b1), "R7 oe_n", 64'(oe), 64'(in_b ? (c == 0) : 1'b1));
        if (in_b) begin
            ck = (c == 0) ? r : col_of(c0, k);
            chk(addr == ck, (c == 0) ? "R2 row addr" : "R4 col addr", 64'(addr), 64'(ck));
        end
        exp_val = (c >= F) && (c <= t) && (((c - F) % n) == 0);
        chk(val == exp_val, "R8 rsp_valid", 64'(val), 64'(exp_val));
        if (exp_val) begin
            ck = col_of(c0, (c - F) / n);
            chk(data == pat(r, ck), "R8 rsp_data", data, pat(r, ck));
            chk(word == ck[1:0], "R8 rsp_word", 64'(word), 64'(ck[1:0]));
        end
        chk(dn == (c == t), "R9 rsp_done", 64'(dn), 64'(c == t));
        chk(rdy == (c >= t + P - 1), "R10 R11 req_ready", 64'(rdy), 64'(c >= t + P - 1));
    endtask

    // One request to both instances, optionally with a stray start mid-burst.
    task automatic run_pair(input logic [27:0] ln, input logic [13:0] exp_last, input bit stray);
        @(negedge clk);
        line = ln; start_f = 1'b1; start_e = 1'b1;
        @(posedge clk);
        for (int c = 0; c <= TF + P + 1; c++) begin
            @(negedge clk);
            if (c == 0) begin start_f = 1'b0; start_e = 1'b0; line = ~ln; end
            if (stray && c == 6) begin start_f = 1'b1; start_e = 1'b1; end
            if (stray && c == 7) begin start_f = 1'b0; start_e = 1'b0; end
            check_cycle(c, 1'b0, ln, ras_f, cas_f, oe_f, addr_f, val_f, data_f, word_f, done_f, rdy_f);
            check_cycle(c, 1'b1, ln, ras_e, cas_e, oe_e, addr_e, val_e, data_e, word_e, done_e, rdy_e);
            if (c == F + 2 * NF + 1)
                chk(addr_f == exp_last, "R4 last column wrap", 64'(addr_f), 64'(exp_last));
            if (c == F + 2 * NE + 1)
                chk(addr_e == exp_last, "R4 last column wrap edo", 64'(addr_e), 64'(exp_last));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int hi_run;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ras_f && cas_f && oe_f, "R1 strobes in reset", {ras_f, cas_f, oe_f}, 3'b111);
        chk(rdy_f && !val_f && !done_f, "R1 ready in reset", {rdy_f, val_f, done_f}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_e && cas_e && oe_e && rdy_e && !val_e, "R1 idle after reset",
            {ras_e, cas_e, oe_e, rdy_e, val_e}, 5'b11110);

        // Vector walk on both cadences; vector 2 also carries a stray start (R11).
        for (int i = 0; i < 6; i++)
            run_pair(VEC[i][41:14], VEC[i][13:0], i == 2);

        // R10: back-to-back request on the fast-page instance.
        @(negedge clk);
        line = {14'h0ABC, 14'h0004}; start_f = 1'b1;
        @(posedge clk);
        hi_run = 0;
        for (int c = 0; c <= TF + P + 2; c++) begin
            @(negedge clk);
            if (c == 0) start_f = 1'b0;
            if (c >= TF && ras_f) hi_run++;
            if (c == TF + P - 1) begin
                chk(rdy_f == 1'b1, "R10 ready in last precharge cycle", 64'(rdy_f), 64'd1);
                line = {14'h1357, 14'h0009}; start_f = 1'b1;
            end
            if (c == TF + P) begin
                start_f = 1'b0;
                chk(ras_f == 1'b0, "R10 row reopened", 64'(ras_f), 64'd0);
                chk(addr_f == 14'h1357, "R10 R2 second row", 64'(addr_f), 64'h1357);
            end
        end
        chk(hi_run == P, "R10 precharge width", 64'(hi_run), 64'(P));
        repeat (TF + P + 2) @(negedge clk);
        chk(ras_f && rdy_f, "R10 idle after second burst", {ras_f, rdy_f}, 2'b11);

        // R1: reset taken in the middle of a burst.
        @(negedge clk);
        line = {14'h0222, 14'h0111}; start_f = 1'b1; start_e = 1'b1;
        @(posedge clk);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (c == 0) begin start_f = 1'b0; start_e = 1'b0; end
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk(ras_f && cas_f && oe_f && !val_f && rdy_f, "R1 mid-burst reset fpm",
            {ras_f, cas_f, oe_f, val_f, rdy_f}, 5'b11101);
        chk(ras_e && cas_e && oe_e && !val_e && rdy_e, "R1 mid-burst reset edo",
            {ras_e, cas_e, oe_e, val_e, rdy_e}, 5'b11101);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(ras_f && ras_e && !val_f && !val_e, "R1 stays idle after reset",
            {ras_f, ras_e, val_f, val_e}, 4'b1100);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule